// File: doc/BRIEF.md
# Wait-State Memory Slave for an AHB-Lite Bus

This block is a small word-organised memory that answers on an AHB-Lite bus. A transfer starts at a clock edge where the slave is selected, the transfer type is NONSEQ and the system ready input is high. At that edge the slave latches the word index and the direction, and the following cycles form the data phase. A read returns the stored word on the read-data output during the data phase. A write stores the write-data bus at the edge that closes the data phase.

Every data phase is stretched by a fixed number of wait states, chosen by a parameter from 0 to 3. While it waits, the slave holds its ready output low. Because the system ready is formed from all slave ready outputs, it is also low during these cycles, so the next pipelined address stays on the bus and is not taken until the stretch ends. The slave responds ready at once to idle cycles, to cycles where it is not selected, and to cycles when it is not busy.

Top module: `ahbw_mem_slave`

## Requirements
- R1: While reset is asserted and after it is released, the ready output is high, the read-data output is zero, and no data phase is pending.
- R2: The transfer type is coded IDLE=00, BUSY=01, NONSEQ=10, SEQ=11. Only an edge with select high, type NONSEQ and system ready high starts a transfer. After any other edge with system ready high, the ready output is high and the read-data output is zero in the next cycle, and the memory is unchanged.
- R3: After a transfer starts, the ready output is low for exactly WAIT_STATES cycles and then high for one cycle, which ends the data phase.
- R4: A write stores the value that the write-data bus carries at the edge that closes the data phase. Values shown on that bus during wait cycles are not stored.
- R5: During the data phase of a read, the read-data output carries the addressed word. Outside a read data phase it is zero.
- R6: While the system ready input is low and the slave has no data phase pending, no transfer is accepted and the latched address-phase state is held.
- R7: Transfers pipeline back to back: a read whose address phase overlaps the data phase of a write to the same word returns the newly written value.
- R8: The word index is taken from address bits [BYTE_OFF+IDX_W-1:BYTE_OFF], where BYTE_OFF is 2 for 32-bit data. The lower byte-offset bits and all higher bits are ignored, so addresses that differ only in those bits reach the same word.
- R9: An asynchronous active-low reset in the middle of a data phase drives the ready output high and the read-data output to zero at once. The aborted access writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Slave select for the current address phase |
| addr_i | input | ADDR_W | Byte address of the address phase |
| trans_i | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| write_i | input | 1 | Direction: 1 = write, 0 = read |
| wdata_i | input | DATA_W | Write data, sampled at the end of the data phase |
| ready_i | input | 1 | System-wide ready fed back from the bus |
| rdata_o | output | DATA_W | Read data during a read data phase |
| readyout_o | output | 1 | This slave's ready, low during wait states |

## Verification
The bench targets these corner cases:
- A write data phase followed straight away by a read of the same word. If the read path sampled memory at the address edge, this read would return the old value.
- Write data that changes on every wait cycle. A design that latched the bus too early would store one of these intermediate values.
- A NONSEQ request made while an external stall holds system ready low. A design that ignored the ready input would start a phantom transfer, and the ready output would show its wait states.
- BUSY, SEQ and unselected cycles, which must give zero-wait responses.
- Addresses that alias in their ignored bits.
- A reset in the middle of a phase.

// File: rtl/ahbw_pkg.sv
package ahbw_pkg;

   typedef enum logic [1:0] {
      TR_IDLE   = 2'b00,
      TR_BUSY   = 2'b01,
      TR_NONSEQ = 2'b10,
      TR_SEQ    = 2'b11
   } trans_e;

   function automatic logic starts_xfer(input logic sel, input logic [1:0] trans, input logic rdy);
      return sel && (trans_e'(trans) == TR_NONSEQ) && rdy;
   endfunction

endpackage

// File: rtl/ahbw_addr_capture.sv
module ahbw_addr_capture #(
   parameter int IDX_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sel_i,
   input  logic [1:0]       trans_i,
   input  logic             write_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             ready_i,
   output logic             start_o,
   output logic             dph_valid_o,
   output logic             dph_write_o,
   output logic [IDX_W-1:0] dph_idx_o
);
   import ahbw_pkg::*;

   assign start_o = starts_xfer(sel_i, trans_i, ready_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dph_valid_o <= 1'b0;
         dph_write_o <= 1'b0;
         dph_idx_o   <= '0;
      end else if (ready_i) begin
         dph_valid_o <= start_o;
         if (start_o) begin
            dph_write_o <= write_i;
            dph_idx_o   <= idx_i;
         end
      end
   end

   AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ready_i |=> ($stable(dph_valid_o) && $stable(dph_idx_o) && $stable(dph_write_o))); // R6

endmodule

// File: rtl/ahbw_wait_gen.sv
module ahbw_wait_gen #(
   parameter int WAIT_STATES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic dph_valid_i,
   output logic ready_o
);
   generate
      if (WAIT_STATES == 0) begin : g_no_wait
         logic unused_wait_in;
         assign unused_wait_in = ^{clk_i, rst_ni, start_i, dph_valid_i};
         assign ready_o = 1'b1;
      end else begin : g_counted
         localparam int CW = $clog2(WAIT_STATES + 1);
         localparam logic [CW-1:0] LOAD = CW'(WAIT_STATES);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)            cnt_q <= '0;
            else if (start_i)       cnt_q <= LOAD;
            else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
         end

         assign ready_o = !(dph_valid_i && (cnt_q != '0));

         AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cnt_q <= LOAD); // R3
         AST_FIRST_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
            start_i |=> !ready_o); // R3
         AST_LAST_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (dph_valid_i && cnt_q == CW'(1)) |=> ready_o); // R3
      end
   endgenerate

endmodule

// File: rtl/ahbw_store.sv
module ahbw_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk_i,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) mem_q[idx_i] <= wdata_i;
   end

   assign rdata_o = mem_q[idx_i];

endmodule

// File: rtl/ahbw_mem_slave.sv
module ahbw_mem_slave #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int DEPTH       = 16,
   parameter int WAIT_STATES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              sel_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        trans_i,
   input  logic              write_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              ready_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              readyout_o
);
   localparam int IDX_W    = $clog2(DEPTH);
   localparam int BYTE_OFF = $clog2(DATA_W / 8);
   localparam int IDX_TOP  = BYTE_OFF + IDX_W;

   generate
      if (DEPTH < 16 || DEPTH > 64 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two from 16 to 64");
      end
      if (WAIT_STATES < 0 || WAIT_STATES > 3) begin : g_bad_wait
         $error("WAIT_STATES must lie in 0..3");
      end
      if (DATA_W != 16 && DATA_W != 32 && DATA_W != 64) begin : g_bad_data
         $error("DATA_W must be 16, 32 or 64");
      end
      if (ADDR_W <= IDX_TOP) begin : g_bad_addr
         $error("ADDR_W too narrow for DEPTH");
      end
   endgenerate

   logic              start;
   logic              dph_valid;
   logic              dph_write;
   logic [IDX_W-1:0]  dph_idx;
   logic [DATA_W-1:0] store_rd;
   logic              wr_en;
   logic              unused_addr;

   assign unused_addr = ^{addr_i[ADDR_W-1:IDX_TOP], addr_i[BYTE_OFF-1:0]};

   ahbw_addr_capture #(.IDX_W(IDX_W)) u_capture (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_i       (sel_i),
      .trans_i     (trans_i),
      .write_i     (write_i),
      .idx_i       (addr_i[BYTE_OFF +: IDX_W]),
      .ready_i     (ready_i),
      .start_o     (start),
      .dph_valid_o (dph_valid),
      .dph_write_o (dph_write),
      .dph_idx_o   (dph_idx)
   );

   ahbw_wait_gen #(.WAIT_STATES(WAIT_STATES)) u_wait (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start),
      .dph_valid_i (dph_valid),
      .ready_o     (readyout_o)
   );

   assign wr_en = dph_valid && dph_write && readyout_o && ready_i;

   ahbw_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk_i   (clk_i),
      .we_i    (wr_en),
      .idx_i   (dph_idx),
      .wdata_i (wdata_i),
      .rdata_o (store_rd)
   );

   assign rdata_o = (dph_valid && !dph_write) ? store_rd : '0;

   AST_IDLE_ZERO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_i && !start) |=> (readyout_o && rdata_o == '0)); // R2
   AST_NO_WRITE_IN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!readyout_o) |-> !wr_en); // R4

endmodule

// File: tb/tb_ahbw_mem_slave.sv
`timescale 1ns/1ps
module tb_ahbw_mem_slave;
   localparam int ADDR_W = 32, DATA_W = 32, DEPTH = 16, WAIT_STATES = 2;
   localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sel = 1'b0, wr = 1'b0, stall = 1'b0;
   logic [1:0] trans = T_IDLE;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0, rdata;
   logic readyout, ready_sys;

   int n_tests = 0, n_fail = 0;
   logic [DATA_W-1:0] mem_m [DEPTH];
   bit exp_valid = 0, exp_write = 0;
   int exp_cnt = 0, exp_idx = 0, low_seen = 0;
   logic [DATA_W-1:0] last_rd = '0;

   always #10 clk = ~clk;
   assign ready_sys = readyout & ~stall;

   ahbw_mem_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .WAIT_STATES(WAIT_STATES)) dut (
      .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .addr_i(addr), .trans_i(trans),
      .write_i(wr), .wdata_i(wdata), .ready_i(ready_sys), .rdata_o(rdata), .readyout_o(readyout));

   function automatic int idx_of(input logic [ADDR_W-1:0] a);
      return int'((a >> 2) % DEPTH);
   endfunction

   task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a negedge; checks outputs, drives one address phase, advances one cycle
   task automatic step(input bit s, input logic [1:0] t, input bit w, input logic [ADDR_W-1:0] a, input bit st);
      bit er, rdy;
      logic [DATA_W-1:0] wd;
      er = !exp_valid || exp_cnt == 0;
      check(exp_valid ? "R3" : "R2", {31'd0, readyout}, {31'd0, er});
      if (!readyout) low_seen++;
      if (exp_valid && !exp_write) begin
         check("R5", rdata, mem_m[exp_idx]);
         if (er) last_rd = rdata;
      end else check("R5", rdata, '0);
      wd = $urandom;
      sel = s; trans = t; wr = w; addr = a; stall = st && !exp_valid; wdata = wd;
      rdy = er && !stall;
      @(posedge clk);
      if (exp_valid && exp_write && rdy) mem_m[exp_idx] = wd;
      if (exp_valid && !rdy) begin
         if (exp_cnt > 0) exp_cnt--;
      end else if (rdy) begin
         if (s && t == T_NSEQ) begin
            exp_valid = 1; exp_write = w; exp_idx = idx_of(a); exp_cnt = WAIT_STATES;
         end else exp_valid = 0;
      end
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, T_IDLE, 0, '0, 0);
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
      @(negedge clk); @(negedge clk);
      check("R1", {31'd0, readyout}, 32'd1);
      check("R1", rdata, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {31'd0, readyout}, 32'd1);

      // fill every word with back-to-back writes
      for (int i = 0; i < DEPTH; i++) step(1, T_NSEQ, 1, ADDR_W'(i * 4), 0);
      idle(WAIT_STATES + 2);

      // R3: count wait cycles of one read
      low_seen = 0;
      step(1, T_NSEQ, 0, 32'h8, 0);
      idle(WAIT_STATES + 2);
      check("R3", low_seen, WAIT_STATES);

      // R7 and R4: write then pipelined read of the same word
      step(1, T_NSEQ, 1, 32'h14, 0);
      step(1, T_NSEQ, 0, 32'h14, 0);
      for (int i = 0; i < WAIT_STATES; i++) step(1, T_NSEQ, 0, 32'h14, 0);
      idle(WAIT_STATES + 2);
      check("R7", last_rd, mem_m[5]);
      check("R4", last_rd, mem_m[5]);

      // R8: aliased address reaches the same word
      step(1, T_NSEQ, 0, 32'h14 + DEPTH * 4 + 3, 0);
      idle(WAIT_STATES + 2);
      check("R8", last_rd, mem_m[5]);

      // R2: non-NONSEQ types and deselected cycles stay zero-wait
      low_seen = 0;
      step(1, T_BUSY, 1, 32'h0, 0);
      step(1, T_SEQ, 1, 32'h4, 0);
      step(0, T_NSEQ, 1, 32'h8, 0);
      step(1, T_IDLE, 1, 32'hC, 0);
      idle(1);
      check("R2", low_seen, 0);

      // R6: request during external stall is not taken
      low_seen = 0;
      step(1, T_NSEQ, 1, 32'h18, 1);
      idle(WAIT_STATES + 1);
      check("R6", low_seen, 0);
      step(1, T_NSEQ, 0, 32'h18, 0);
      idle(WAIT_STATES + 2);
      check("R6", last_rd, mem_m[6]);

      // R9: reset during a wait state
      step(1, T_NSEQ, 1, 32'h1C, 0);
      rst_n = 1'b0;
      #1;
      check("R9", {31'd0, readyout}, 32'd1);
      check("R9", rdata, '0);
      exp_valid = 0; exp_cnt = 0;
      sel = 0; trans = T_IDLE;
      @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
      idle(1);
      step(1, T_NSEQ, 0, 32'h1C, 0);
      idle(WAIT_STATES + 2);
      check("R9", last_rd, mem_m[7]);

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         step(($urandom % 4) != 0, 2'($urandom % 4), 1'($urandom % 2),
              ADDR_W'($urandom & 32'hFF), ($urandom % 8) == 0);
      end
      idle(WAIT_STATES + 2);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule